// File: doc/BRIEF.md
# Scaled 48-bit Real-Time Counter

This block keeps a 48-bit time count that advances by one on each slow, always-on tick pulse while counting is enabled. Software reaches it through a small register port: the count is read and loaded as a 32-bit lower word and a 16-bit upper word. A 4-bit scale selects a 32-bit window of the count, namely the count shifted right by the scale. That window can be read directly and is compared against a match register. The tick is expected at a nominal 31250 Hz, one cycle wide, and synchronous to `clk`.

Whenever the scaled window is greater than or equal to the match value, the block raises its interrupt output and shows a pending flag in the control register. The flag follows the comparison and needs no separate clearing. Software clears the interrupt by moving the match value ahead of the window or by loading a new count. A read request returns its data one cycle later, marked by `rvalid`. The read response cannot be stalled, so no ready signal exists on either side.

Register offsets: control 0x00, count lower word 0x08, count upper word 0x0C, scaled window 0x10 (read-only), match 0x20. Control layout: scale in bits [3:0], count enable in bit 12, pending flag in bit 28 (read-only).

Top module: `rtc_scaled_counter`

## Requirements
- R1: After reset the count is zero, scale and enable are zero, the match register holds 0xFFFFFFFF, and `irq` is low.
- R2: While control bit 12 is set, each cycle with `tick` high and no count write adds one to the 48-bit count. A cycle without `tick` leaves the count unchanged.
- R3: While control bit 12 is clear, the count holds its value whatever `tick` does.
- R4: A write to 0x0C loads count bits [47:32] from `wdata[15:0]` and leaves bits [31:0] unchanged. A read of 0x0C returns those 16 bits with bits [31:16] zero.
- R5: A write to 0x08 loads count bits [31:0] and leaves bits [47:32] unchanged. A count write in the same cycle as an enabled tick wins, and no increment happens in that cycle.
- R6: An enabled tick that carries out of the lower word updates both words in the same cycle.
- R7: A read of 0x10 returns count bits [scale+31:scale], the count shifted right by the scale in control bits [3:0].
- R8: `irq` and control bit 28 are high exactly when the scaled window is greater than or equal to the match register.
- R9: `rvalid` is high in the cycle after a cycle with `rd_en` high and low otherwise. `rdata` then holds the register value from the request cycle. Unmapped offsets read as zero.
- R10: A control write stores only bits [3:0] and bit 12. Writing other bits, including bit 28, has no effect, and those bits read back as zero apart from the live pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | Read response valid, one cycle after `rd_en` |
| irq | output | 1 | Compare interrupt, level |

## Verification
Some rules are checked on every cycle: the hold of the count while disabled, the increment on an enabled tick, the half-word loads with their priority over ticks, the one-cycle read response, and the relation between `irq` and a separately computed scaled window. Other behaviour only the directed scenarios can show at the ports: the carry into the upper word, the window selected by each scale value, the read-back masking of the control and upper registers, and the exact compare boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LOW   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_HIGH  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_WIN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 8'h20;
  localparam int BIT_RUN  = 12;
  localparam int BIT_PEND = 28;
endpackage

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W  = 48,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             ld_low,
  input  logic             ld_high,
  input  logic [WORD_W-1:0] ld_data,
  output logic [CNT_W-1:0] count
);
  localparam int HI_W = CNT_W - WORD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ld_low || ld_high) begin
      if (ld_low)  count[WORD_W-1:0]     <= ld_data;
      if (ld_high) count[CNT_W-1:WORD_W] <= ld_data[HI_W-1:0];
    end else if (tick && run) begin
      count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_window.sv
module rtc_window #(
  parameter int CNT_W   = 48,
  parameter int WORD_W  = 32,
  parameter int SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [SCALE_W-1:0] scale,
  input  logic [WORD_W-1:0]  match_val,
  output logic [WORD_W-1:0]  window,
  output logic               hit
);
  logic [CNT_W-1:0] shifted;

  always_comb begin
    shifted = count >> scale;
    window  = shifted[WORD_W-1:0];
    hit     = (window >= match_val);
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int WORD_W  = 32,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   count,
  input  logic [WORD_W-1:0]  window,
  input  logic               hit,
  output logic [SCALE_W-1:0] scale,
  output logic               run,
  output logic [WORD_W-1:0]  match_val,
  output logic [WORD_W-1:0]  rdata,
  output logic               rvalid
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [WORD_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale     <= '0;
      run       <= 1'b0;
      match_val <= '1;
    end else if (wr_en) begin
      if (addr == OFF_CTRL) begin
        scale <= wdata[SCALE_W-1:0];
        run   <= wdata[BIT_RUN];
      end
      if (addr == OFF_MATCH) match_val <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_CTRL: begin
        rd_mux[SCALE_W-1:0] = scale;
        rd_mux[BIT_RUN]     = run;
        rd_mux[BIT_PEND]    = hit;
      end
      OFF_LOW:   rd_mux = count[WORD_W-1:0];
      OFF_HIGH:  rd_mux[HI_W-1:0] = count[CNT_W-1:WORD_W];
      OFF_WIN:   rd_mux = window;
      OFF_MATCH: rd_mux = match_val;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_scaled_counter.sv
module rtc_scaled_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int WORD_W  = 32,
  parameter int SCALE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq
);
  logic [CNT_W-1:0]   count_q;
  logic [SCALE_W-1:0] scale_q;
  logic               run_q;
  logic [WORD_W-1:0]  match_q;
  logic [WORD_W-1:0]  window;
  logic               hit;
  logic               ld_low, ld_high;

  assign ld_low  = wr_en && (addr == OFF_LOW);
  assign ld_high = wr_en && (addr == OFF_HIGH);

  rtc_count_core #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q),
    .ld_low(ld_low), .ld_high(ld_high), .ld_data(wdata), .count(count_q)
  );

  rtc_window #(.CNT_W(CNT_W), .WORD_W(WORD_W), .SCALE_W(SCALE_W)) u_win (
    .count(count_q), .scale(scale_q), .match_val(match_q),
    .window(window), .hit(hit)
  );

  rtc_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W), .SCALE_W(SCALE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count_q), .window(window), .hit(hit),
    .scale(scale_q), .run(run_q), .match_val(match_q),
    .rdata(rdata), .rvalid(rvalid)
  );

  assign irq = hit;
endmodule

// File: rtl/rtc_scaled_counter_chk.sv
module rtc_scaled_counter_chk
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int WORD_W  = 32,
  parameter int SCALE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               wr_en,
  input logic               rd_en,
  input logic [7:0]         addr,
  input logic [WORD_W-1:0]  wdata,
  input logic               rvalid,
  input logic               irq,
  input logic [CNT_W-1:0]   count_q,
  input logic [SCALE_W-1:0] scale_q,
  input logic               run_q,
  input logic [WORD_W-1:0]  match_q
);
  localparam int HI_W = CNT_W - WORD_W;

  logic cnt_wr;
  logic [WORD_W-1:0] ref_window;
  assign cnt_wr     = wr_en && (addr == OFF_LOW || addr == OFF_HIGH);
  assign ref_window = count_q[scale_q +: WORD_W];

  // R2
  assert_inc_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && !cnt_wr) |=> count_q == $past(count_q) + CNT_W'(1));

  // R3
  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(count_q));

  // R4
  assert_high_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_HIGH) |=>
      (count_q[CNT_W-1:WORD_W] == $past(wdata[HI_W-1:0]) &&
       count_q[WORD_W-1:0] == $past(count_q[WORD_W-1:0])));

  // R5
  assert_low_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_LOW) |=>
      (count_q[WORD_W-1:0] == $past(wdata) &&
       count_q[CNT_W-1:WORD_W] == $past(count_q[CNT_W-1:WORD_W])));

  // R8
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ref_window >= match_q));

  // R9
  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

bind rtc_scaled_counter rtc_scaled_counter_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rvalid(rvalid), .irq(irq),
  .count_q(count_q), .scale_q(scale_q), .run_q(run_q), .match_q(match_q)
);

// File: tb/tb_rtc_scaled_counter.sv
module tb_rtc_scaled_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_scaled_counter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 rvalid", {31'b0, rvalid}, 32'h1);
    d = rdata;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h08, v); chk("R1 low", v, 32'h0);
    rd(8'h0C, v); chk("R1 high", v, 32'h0);
    rd(8'h20, v); chk("R1 match", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1000);
    pulse_ticks(5);
    repeat (4) @(negedge clk);
    rd(8'h08, v); chk("R2 five ticks", v, 32'd5);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    pulse_ticks(3);
    rd(8'h08, v); chk("R3 held", v, 32'd5);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'hABCD_BEEF);
    rd(8'h0C, v); chk("R4 high masked", v, 32'h0000_BEEF);
    rd(8'h08, v); chk("R4 low kept", v, 32'h1234_5678);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_0001);
    wr(8'h00, 32'h0000_1000);
    pulse_ticks(1);
    wr(8'h00, 32'h0);
    rd(8'h08, v); chk("R6 low wrapped", v, 32'h0);
    rd(8'h0C, v); chk("R6 high carried", v, 32'h2);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1000);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h08; wdata = 32'h100;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    wr(8'h00, 32'h0);
    rd(8'h08, v); chk("R5 write wins", v, 32'h100);
    rd(8'h0C, v); chk("R5 high untouched", v, 32'h2);
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr(8'h08, 32'h8000_0000);
    wr(8'h0C, 32'h0000_0003);
    wr(8'h00, 32'h0);
    rd(8'h10, v); chk("R7 scale 0", v, 32'h8000_0000);
    wr(8'h00, 32'h4);
    rd(8'h10, v); chk("R7 scale 4", v, 32'h3800_0000);
    wr(8'h00, 32'hF);
    rd(8'h10, v); chk("R7 scale 15", v, 32'h0007_0000);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h8000_0001);
    chk("R8 below", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R8 flag clear", v, 32'h0);
    wr(8'h20, 32'h8000_0000);
    chk("R8 equal", {31'b0, irq}, 32'h1);
    rd(8'h00, v); chk("R8 flag set", v, 32'h1000_0000);
    wr(8'h20, 32'h7FFF_FFFF);
    chk("R8 above", {31'b0, irq}, 32'h1);
    wr(8'h20, 32'hFFFF_FFFF);
    chk("R8 cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_mask();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R10 masked ctrl", v, 32'h0000_100F);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_read_rules();
    logic [31:0] v;
    rd(8'h04, v); chk("R9 unmapped", v, 32'h0);
    @(negedge clk);
    chk("R9 idle rvalid", {31'b0, rvalid}, 32'h0);
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h08;
    wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h08;
    wr_en = 1'b1; wdata = 32'hCAFE_0000;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R9 pre-write value", rdata, 32'h8000_0000);
    rd(8'h08, v); chk("R9 after write", v, 32'hCAFE_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_hold();
    t_halves();
    t_carry();
    t_priority();
    t_window();
    t_compare();
    t_ctrl_mask();
    t_read_rules();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule